// File: doc/BRIEF.md
# Test Coprocessor with Timed Interrupts

This block is a verification aid that sits on a processor's coprocessor port and answers on two coprocessor numbers, called the primary unit and the secondary unit. It holds sixteen 32-bit registers that either unit can write or read with register-move transfers. Memory load and store transfers are accepted by the primary unit only. A long transfer streams a fixed burst of five data beats into or out of one register.

Data-operation commands let a test program stall the core for a number of cycles held in a register. They can also drive the active-low fast and normal interrupt lines low after a programmed delay, release those lines, and capture a free-running cycle counter into a register. All responses are combinational in the cycle of the request. Register writes, interrupt line changes and counter updates take effect at the next rising clock edge.

Top module: `tcp_timed_copro`

## Requirements
- R1: After reset `fiq_n` and `irq_n` are high, every register reads zero and the cycle counter is zero. While `req_valid` is low, `resp` is 0 (done) and `rd_data` is zero.
- R2: The request kind codes are: 0 move-to (write register `req_rn` with `wr_data`), 1 move-from (read register `req_rn` on `rd_data`), 2 load, 3 store, 4 data operation. Codes 5 to 7 answer cannot. The response codes are: 0 done, 1 busy, 2 increment, 3 cannot. A move on either unit (`req_unit` 0 or 1) answers done, and a written value reads back on the other unit.
- R3: The phase codes are: 0 first, 1 busy, 2 data. On the primary unit, a load or store uses register `req_rd`. In any non-data phase it answers done. In the data phase with `req_long` low, a load writes `wr_data` and a store drives the register on `rd_data`, each answering done. On the secondary unit, a load or store answers cannot and writes nothing.
- R4: With `req_long` high, the first four data beats answer increment and the fifth answers done. Each beat loads into, or stores from, the same register. A non-data phase restarts the beat count.
- R5: Data operation opcode 0 (`req_opc`) on either unit is a busy-wait on the value N of register `req_rm`. In the first phase it answers done if N is 0 and busy otherwise. A busy-phase poll k cycles after the first cycle answers done when k is at least N and busy before that.
- R6: On the primary unit every data-operation opcode other than 0 answers cannot. On the secondary unit opcodes 6 to 15 answer cannot. A cannot response changes no register and no interrupt line.
- R7: Secondary opcode 1 (for `fiq_n`) and opcode 2 (for `irq_n`) take a delay N from register `req_rm`. The line is first seen low N+1 cycles after the command cycle, or 1 cycle after when N is 0. It stays low until it is released.
- R8: Secondary opcode 3 sets `fiq_n` high and opcode 4 sets `irq_n` high, each from the next cycle.
- R9: Each line keeps one pending delayed event. A new schedule command for that line replaces the pending one, and the earlier delay never takes effect.
- R10: Secondary opcode 5 writes into register `req_rm` the cycle count of the command cycle, zero-extended. The count is the number of rising edges since reset released, modulo 2^CNT_W.
- R11: The cycle counter wraps at 2^CNT_W. Busy-wait and interrupt delays below 2^(CNT_W-1) behave the same when the finish time lies past the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A coprocessor request is presented this cycle |
| req_unit | input | 1 | 0 primary unit, 1 secondary unit |
| req_kind | input | 3 | Request kind code |
| req_phase | input | 2 | Handshake phase code |
| req_opc | input | 4 | Data-operation opcode field |
| req_rn | input | 4 | Register index for moves |
| req_rd | input | 4 | Register index for loads and stores |
| req_rm | input | 4 | Operand register index for data operations |
| req_long | input | 1 | Long (five-beat) load or store |
| wr_data | input | 32 | Data from the core |
| resp | output | 2 | Response code |
| rd_data | output | 32 | Data to the core |
| fiq_n | output | 1 | Active-low fast interrupt |
| irq_n | output | 1 | Active-low normal interrupt |

## Verification
The hardest case to reach from the ports is a finish time that lies beyond the counter wrap. At full width, that takes billions of cycles. The bench therefore builds the block with a 10-bit counter. It idles until its own edge count, modulo 1024, sits a few cycles before the wrap. It then starts a busy-wait, a timestamp capture and a delayed interrupt there, and checks that each one completes exactly on time.

// File: rtl/tcp_pkg.sv
package tcp_pkg;

    typedef enum logic [2:0] {
        K_MOVE_TO   = 3'd0,
        K_MOVE_FROM = 3'd1,
        K_LOAD      = 3'd2,
        K_STORE     = 3'd3,
        K_OP        = 3'd4
    } kind_e;

    typedef enum logic [1:0] {
        PH_FIRST = 2'd0,
        PH_BUSY  = 2'd1,
        PH_DATA  = 2'd2,
        PH_RSVD  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        R_DONE = 2'd0,
        R_BUSY = 2'd1,
        R_INC  = 2'd2,
        R_CANT = 2'd3
    } resp_e;

    typedef enum logic [1:0] {
        W_RN = 2'd0,
        W_RD = 2'd1,
        W_RM = 2'd2
    } wsel_e;

    localparam int NLINES = 2;

    typedef struct packed {
        logic              we;
        wsel_e             wsel;
        logic              wsrc_cnt;
        logic              rd_en;
        logic              rd_from_rd;
        logic              beat_clr;
        logic              beat_inc;
        logic              fin_ld;
        logic [NLINES-1:0] sched;
        logic [NLINES-1:0] rel;
    } act_t;

endpackage

// File: rtl/tcp_regfile.sv
module tcp_regfile #(
    parameter int NREG = 16,
    parameter int DW   = 32,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ra_idx,
    output logic [DW-1:0] ra_data,
    input  logic [IW-1:0] rb_idx,
    output logic [DW-1:0] rb_data
);
    logic [DW-1:0] regs_d [NREG];
    logic [DW-1:0] regs_q [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) regs_d[i] = regs_q[i];
        if (we) regs_d[widx] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= regs_d[i];
        end
    end

    assign ra_data = regs_q[ra_idx];
    assign rb_data = regs_q[rb_idx];

endmodule

// File: rtl/tcp_decode.sv
module tcp_decode
    import tcp_pkg::*;
(
    input  logic   valid,
    input  logic   unit,
    input  kind_e  kind,
    input  phase_e phase,
    input  logic [3:0] opc,
    input  logic   lng,
    input  logic   op_zero,
    input  logic   wait_hit,
    input  logic   beat_last,
    output resp_e  resp,
    output act_t   act
);
    always_comb begin
        resp = R_DONE;
        act  = '0;
        if (valid) begin
            case (kind)
                K_MOVE_TO: begin
                    act.we   = 1'b1;
                    act.wsel = W_RN;
                end
                K_MOVE_FROM: act.rd_en = 1'b1;
                K_LOAD, K_STORE: begin
                    if (unit) begin
                        resp = R_CANT;
                    end else if (phase != PH_DATA) begin
                        act.beat_clr = 1'b1;
                    end else begin
                        if (kind == K_LOAD) begin
                            act.we   = 1'b1;
                            act.wsel = W_RD;
                        end else begin
                            act.rd_en      = 1'b1;
                            act.rd_from_rd = 1'b1;
                        end
                        if (lng && !beat_last) begin
                            resp         = R_INC;
                            act.beat_inc = 1'b1;
                        end
                    end
                end
                K_OP: begin
                    if (opc == 4'd0) begin
                        case (phase)
                            PH_FIRST: begin
                                act.fin_ld = 1'b1;
                                resp = op_zero ? R_DONE : R_BUSY;
                            end
                            PH_BUSY: resp = wait_hit ? R_DONE : R_BUSY;
                            default: resp = R_CANT;
                        endcase
                    end else if (!unit) begin
                        resp = R_CANT;
                    end else begin
                        case (opc)
                            4'd1: act.sched[0] = 1'b1;
                            4'd2: act.sched[1] = 1'b1;
                            4'd3: act.rel[0]   = 1'b1;
                            4'd4: act.rel[1]   = 1'b1;
                            4'd5: begin
                                act.we       = 1'b1;
                                act.wsel     = W_RM;
                                act.wsrc_cnt = 1'b1;
                            end
                            default: resp = R_CANT;
                        endcase
                    end
                end
                default: resp = R_CANT;
            endcase
        end
    end

endmodule

// File: rtl/tcp_line_timer.sv
module tcp_line_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] delay,
    input  logic             sched,
    input  logic             rel,
    output logic             line_n
);
    typedef struct packed {
        logic             pend;
        logic [CNT_W-1:0] due;
        logic             line;
    } tstate_t;

    tstate_t st_d, st_q;
    logic [CNT_W-1:0] gap;
    logic             fire;

    assign gap  = cnt - st_q.due;
    assign fire = st_q.pend && !gap[CNT_W-1];

    always_comb begin
        st_d = st_q;
        if (sched) begin
            st_d.pend = (delay != '0);
            st_d.due  = cnt + delay;
            if (delay == '0) st_d.line = 1'b0;
        end else if (fire) begin
            st_d.pend = 1'b0;
            st_d.line = 1'b0;
        end
        if (rel) st_d.line = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pend: 1'b0, due: '0, line: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign line_n = st_q.line;

    p_release_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rel |=> line_n);
    p_zero_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sched && delay == '0 && !rel) |=> !line_n);
    p_hold_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_n && !rel) |=> !line_n);

endmodule

// File: rtl/tcp_timed_copro.sv
module tcp_timed_copro
    import tcp_pkg::*;
#(
    parameter int NREG  = 16,
    parameter int DW    = 32,
    parameter int CNT_W = 32,
    parameter int BURST = 5,
    localparam int IW   = $clog2(NREG),
    localparam int BW   = $clog2(BURST + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_unit,
    input  logic [2:0]    req_kind,
    input  logic [1:0]    req_phase,
    input  logic [3:0]    req_opc,
    input  logic [IW-1:0] req_rn,
    input  logic [IW-1:0] req_rd,
    input  logic [IW-1:0] req_rm,
    input  logic          req_long,
    input  logic [DW-1:0] wr_data,
    output logic [1:0]    resp,
    output logic [DW-1:0] rd_data,
    output logic          fiq_n,
    output logic          irq_n
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] fin;
        logic [BW-1:0]    beat;
    } core_t;

    core_t st_d, st_q;
    resp_e resp_w;
    act_t  act;

    logic [DW-1:0]    ra_data, rb_data, wdata;
    logic [IW-1:0]    widx, ra_idx;
    logic [CNT_W-1:0] delay, wait_gap;
    logic             op_zero, wait_hit, beat_last;
    logic [NLINES-1:0] line_n;

    assign delay     = rb_data[CNT_W-1:0];
    assign op_zero   = (delay == '0);
    assign wait_gap  = st_q.cnt - st_q.fin;
    assign wait_hit  = !wait_gap[CNT_W-1];
    assign beat_last = (st_q.beat == BW'(BURST - 1));

    tcp_decode u_dec (
        .valid     (req_valid),
        .unit      (req_unit),
        .kind      (kind_e'(req_kind)),
        .phase     (phase_e'(req_phase)),
        .opc       (req_opc),
        .lng       (req_long),
        .op_zero   (op_zero),
        .wait_hit  (wait_hit),
        .beat_last (beat_last),
        .resp      (resp_w),
        .act       (act)
    );

    always_comb begin
        case (act.wsel)
            W_RD:    widx = req_rd;
            W_RM:    widx = req_rm;
            default: widx = req_rn;
        endcase
        wdata  = act.wsrc_cnt ? DW'(st_q.cnt) : wr_data;
        ra_idx = act.rd_from_rd ? req_rd : req_rn;
    end

    tcp_regfile #(.NREG(NREG), .DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (act.we),
        .widx    (widx),
        .wdata   (wdata),
        .ra_idx  (ra_idx),
        .ra_data (ra_data),
        .rb_idx  (req_rm),
        .rb_data (rb_data)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
        if (act.fin_ld)   st_d.fin  = st_q.cnt + delay;
        if (act.beat_clr) st_d.beat = '0;
        else if (act.beat_inc) st_d.beat = st_q.beat + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        tcp_line_timer #(.CNT_W(CNT_W)) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .cnt    (st_q.cnt),
            .delay  (delay),
            .sched  (act.sched[g]),
            .rel    (act.rel[g]),
            .line_n (line_n[g])
        );
    end

    assign fiq_n   = line_n[0];
    assign irq_n   = line_n[1];
    assign resp    = resp_w;
    assign rd_data = act.rd_en ? ra_data : '0;

    p_unit1_mem_cant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_unit && (req_kind == 3'd2 || req_kind == 3'd3))
        |-> resp == 2'd3);
    p_burst_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (resp == 2'd2) |-> st_q.beat < BW'(BURST - 1));
    p_wait_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 3'd4 && req_opc == 4'd0 && req_phase == 2'd0
         && rb_data[CNT_W-1:0] == '0) |-> resp == 2'd0);
    p_cant_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (resp == 2'd3) |-> (rd_data == '0) ##1 ($stable(fiq_n) && $stable(irq_n)));
    p_cnt_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> st_q.cnt == $past(st_q.cnt) + 1'b1);

endmodule

// File: tb/tcp_timed_copro_tb_top.sv
module tcp_timed_copro_tb_top;
    localparam int CW   = 10;
    localparam int MASK = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_unit = 1'b0, req_long = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [1:0]  req_phase = '0;
    logic [3:0]  req_opc = '0, req_rn = '0, req_rd = '0, req_rm = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  resp;
    logic [31:0] rd_data;
    logic        fiq_n, irq_n;

    int checks = 0, errors = 0, tb_cyc = 0;
    logic [1:0]  got_resp;
    logic [31:0] got_rd;

    always #5 clk = ~clk;
    always @(posedge clk) if (rst_n) tb_cyc <= tb_cyc + 1;

    tcp_timed_copro #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_unit(req_unit),
        .req_kind(req_kind), .req_phase(req_phase), .req_opc(req_opc),
        .req_rn(req_rn), .req_rd(req_rd), .req_rm(req_rm), .req_long(req_long),
        .wr_data(wr_data), .resp(resp), .rd_data(rd_data),
        .fiq_n(fiq_n), .irq_n(irq_n)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] a, input logic [31:0] e);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, a, e);
        end
    endtask

    task automatic drive(input bit u, input logic [2:0] k, input logic [1:0] ph,
                         input logic [3:0] op, input logic [3:0] rn, input logic [3:0] rd,
                         input logic [3:0] rm, input bit lng, input logic [31:0] d);
        req_valid = 1'b1; req_unit = u; req_kind = k; req_phase = ph; req_opc = op;
        req_rn = rn; req_rd = rd; req_rm = rm; req_long = lng; wr_data = d;
        #1;
        got_resp = resp;
        got_rd   = rd_data;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wr_reg(input bit u, input logic [3:0] i, input logic [31:0] v);
        drive(u, 3'd0, 2'd0, 4'd0, i, 4'd0, 4'd0, 1'b0, v);
    endtask

    task automatic rd_reg(input bit u, input logic [3:0] i);
        drive(u, 3'd1, 2'd0, 4'd0, i, 4'd0, 4'd0, 1'b0, 32'd0);
    endtask

    task automatic dop(input bit u, input logic [3:0] op, input logic [3:0] rm, input logic [1:0] ph);
        drive(u, 3'd4, ph, op, 4'd0, 4'd0, rm, 1'b0, 32'd0);
    endtask

    task automatic first_low(input bit use_irq, input int limit, output int k);
        k = 0;
        for (int i = 1; i <= limit; i++) begin
            #1;
            if (k == 0 && (use_irq ? irq_n : fiq_n) == 1'b0) k = i;
            @(negedge clk);
        end
    endtask

    task automatic poll_wait(input bit u, input logic [3:0] rm, input int limit, output int k);
        k = 0;
        for (int i = 1; i <= limit; i++) begin
            dop(u, 4'd0, rm, 2'd1);
            if (got_resp == 2'd0) begin k = i; break; end
        end
    endtask

    task automatic t_reset;
        #1;
        chk(fiq_n === 1'b1 && irq_n === 1'b1, "R1 lines high", {irq_n, fiq_n}, 2'b11);
        chk(resp === 2'd0 && rd_data === 32'd0, "R1 idle resp", resp, 0);
        rd_reg(1'b0, 4'd9);
        chk(got_rd === 32'd0, "R1 reg zero", got_rd, 0);
        rd_reg(1'b1, 4'd15);
        chk(got_rd === 32'd0, "R1 reg15 zero", got_rd, 0);
    endtask

    task automatic t_moves;
        wr_reg(1'b0, 4'd3, 32'hA5A5_1234);
        chk(got_resp === 2'd0, "R2 move resp", got_resp, 0);
        rd_reg(1'b1, 4'd3);
        chk(got_rd === 32'hA5A5_1234, "R2 cross read", got_rd, 32'hA5A5_1234);
        wr_reg(1'b1, 4'd12, 32'h0BAD_F00D);
        rd_reg(1'b0, 4'd12);
        chk(got_rd === 32'h0BAD_F00D && got_resp === 2'd0, "R2 cross read2", got_rd, 32'h0BAD_F00D);
        drive(1'b0, 3'd6, 2'd0, 4'd0, 4'd0, 4'd0, 4'd0, 1'b0, 0);
        chk(got_resp === 2'd3, "R2 bad kind", got_resp, 3);
    endtask

    task automatic t_mem;
        drive(1'b0, 3'd2, 2'd0, 4'd0, 4'd0, 4'd5, 4'd0, 1'b0, 0);
        chk(got_resp === 2'd0, "R3 first phase", got_resp, 0);
        drive(1'b0, 3'd2, 2'd2, 4'd0, 4'd0, 4'd5, 4'd0, 1'b0, 32'h1111_2222);
        chk(got_resp === 2'd0, "R3 single load", got_resp, 0);
        rd_reg(1'b0, 4'd5);
        chk(got_rd === 32'h1111_2222, "R3 load value", got_rd, 32'h1111_2222);
        drive(1'b0, 3'd3, 2'd2, 4'd0, 4'd0, 4'd5, 4'd0, 1'b0, 0);
        chk(got_rd === 32'h1111_2222 && got_resp === 2'd0, "R3 single store", got_rd, 32'h1111_2222);
        drive(1'b1, 3'd2, 2'd2, 4'd0, 4'd0, 4'd5, 4'd0, 1'b0, 32'hDEAD_0000);
        chk(got_resp === 2'd3, "R3 unit1 load cant", got_resp, 3);
        rd_reg(1'b0, 4'd5);
        chk(got_rd === 32'h1111_2222, "R3 unit1 no write", got_rd, 32'h1111_2222);
    endtask

    task automatic t_burst;
        int incs = 0;
        drive(1'b0, 3'd2, 2'd0, 4'd0, 4'd0, 4'd7, 4'd0, 1'b1, 0);
        for (int b = 0; b < 5; b++) begin
            drive(1'b0, 3'd2, 2'd2, 4'd0, 4'd0, 4'd7, 4'd0, 1'b1, 32'h100 + b);
            if (b < 4 && got_resp === 2'd2) incs++;
            if (b == 4) chk(got_resp === 2'd0, "R4 fifth beat done", got_resp, 0);
        end
        chk(incs == 4, "R4 four increments", incs, 4);
        rd_reg(1'b0, 4'd7);
        chk(got_rd === 32'h104, "R4 last beat kept", got_rd, 32'h104);
        drive(1'b0, 3'd3, 2'd0, 4'd0, 4'd0, 4'd7, 4'd0, 1'b1, 0);
        drive(1'b0, 3'd3, 2'd2, 4'd0, 4'd0, 4'd7, 4'd0, 1'b1, 0);
        chk(got_resp === 2'd2 && got_rd === 32'h104, "R4 restart store beat", got_resp, 2);
    endtask

    task automatic t_busy;
        int k;
        wr_reg(1'b0, 4'd2, 32'd6);
        dop(1'b0, 4'd0, 4'd2, 2'd0);
        chk(got_resp === 2'd1, "R5 first busy", got_resp, 1);
        poll_wait(1'b0, 4'd2, 20, k);
        chk(k == 6, "R5 done after N", k, 6);
        wr_reg(1'b0, 4'd1, 32'd0);
        dop(1'b1, 4'd0, 4'd1, 2'd0);
        chk(got_resp === 2'd0, "R5 zero done", got_resp, 0);
        wr_reg(1'b1, 4'd2, 32'd3);
        dop(1'b1, 4'd0, 4'd2, 2'd0);
        poll_wait(1'b1, 4'd2, 20, k);
        chk(k == 3, "R5 unit1 wait", k, 3);
    endtask

    task automatic t_cant;
        int k;
        wr_reg(1'b0, 4'd1, 32'd0);
        wr_reg(1'b0, 4'd4, 32'h4444);
        dop(1'b0, 4'd1, 4'd1, 2'd0);
        chk(got_resp === 2'd3, "R6 unit0 op1 cant", got_resp, 3);
        first_low(1'b0, 4, k);
        chk(k == 0, "R6 no fiq", k, 0);
        dop(1'b0, 4'd5, 4'd4, 2'd0);
        rd_reg(1'b0, 4'd4);
        chk(got_rd === 32'h4444, "R6 unit0 op5 no write", got_rd, 32'h4444);
        dop(1'b1, 4'd9, 4'd4, 2'd0);
        chk(got_resp === 2'd3, "R6 unit1 op9 cant", got_resp, 3);
    endtask

    task automatic t_lines;
        int k;
        wr_reg(1'b0, 4'd8, 32'd7);
        dop(1'b1, 4'd1, 4'd8, 2'd0);
        first_low(1'b0, 12, k);
        chk(k == 8, "R7 fiq delay", k, 8);
        chk(irq_n === 1'b1, "R7 irq untouched", irq_n, 1);
        dop(1'b1, 4'd3, 4'd0, 2'd0);
        #1 chk(fiq_n === 1'b1, "R8 fiq release", fiq_n, 1);
        wr_reg(1'b0, 4'd1, 32'd0);
        dop(1'b1, 4'd2, 4'd1, 2'd0);
        #1 chk(irq_n === 1'b0, "R7 irq zero delay", irq_n, 0);
        @(negedge clk);
        dop(1'b1, 4'd4, 4'd0, 2'd0);
        #1 chk(irq_n === 1'b1, "R8 irq release", irq_n, 1);
        @(negedge clk);
    endtask

    task automatic t_replace;
        int k;
        wr_reg(1'b0, 4'd8, 32'd4);
        wr_reg(1'b0, 4'd10, 32'd20);
        dop(1'b1, 4'd1, 4'd8, 2'd0);
        dop(1'b1, 4'd1, 4'd10, 2'd0);
        first_low(1'b0, 30, k);
        chk(k == 21, "R9 replaced delay", k, 21);
        dop(1'b1, 4'd3, 4'd0, 2'd0);
    endtask

    task automatic t_stamp;
        int e;
        e = tb_cyc & MASK;
        dop(1'b1, 4'd5, 4'd11, 2'd0);
        rd_reg(1'b0, 4'd11);
        chk(got_rd === 32'(e), "R10 timestamp", got_rd, e);
    endtask

    task automatic t_wrap;
        int k;
        wr_reg(1'b0, 4'd2, 32'd12);
        wr_reg(1'b0, 4'd8, 32'd10);
        while ((tb_cyc & MASK) != 1018) @(negedge clk);
        dop(1'b0, 4'd0, 4'd2, 2'd0);
        poll_wait(1'b0, 4'd2, 30, k);
        chk(k == 12, "R11 wait across wrap", k, 12);
        t_stamp();
        while ((tb_cyc & MASK) != 1020) @(negedge clk);
        dop(1'b1, 4'd2, 4'd8, 2'd0);
        first_low(1'b1, 16, k);
        chk(k == 11, "R11 irq across wrap", k, 11);
        dop(1'b1, 4'd4, 4'd0, 2'd0);
    endtask

    initial begin
        #200_000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_moves();
        t_mem();
        t_burst();
        t_busy();
        t_cant();
        t_lines();
        t_replace();
        t_stamp();
        t_wrap();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule